// File: doc/BRIEF.md
# Register-Controlled Reset Generator

This block drives a bank of reset lines (64 by default) from a small memory-mapped register port. Software sets a bit in one of two control words to put the matching line into reset. Most lines are pulse resets: once triggered, each stays active for a fixed number of clock cycles and then releases itself with no further write. Two designated lines, 12 and 56, are level-held instead. They stay in reset until software writes their control bit back to 0.

Line 0 is the whole-core reset, and software pulses it to restart the system. Reading a control word returns which lines are active now. Reading a status word returns the same information with inverted polarity. The register port is single-cycle: a write takes effect at the clock edge where it is sampled, and read data is registered and appears on the next cycle.

Top module: `rst_ctrl_unit`

## Requirements
- R1: After the block's own reset, every output in `reset_out` is 0 (released) and `bus_rdata` is 0.
- R2: Line n belongs to control word n/32, bit n%32. Control word 0 is at byte address 0x100 and covers lines 0–31. Control word 1 is at 0x104 and covers lines 32–63.
- R3: Writing 1 to the control bit of a pulse line drives that line to 1 from the cycle after the write for exactly PULSE_LEN cycles, and then it returns to 0 without any further write.
- R4: Writing 1 again to a pulse line while its pulse is running restarts the full PULSE_LEN count from that write.
- R5: Writing 0 to the control bit of a pulse line does not shorten or affect a pulse that is already running.
- R6: Lines 12 and 56 go to 1 on a write of 1 to their control bit. They stay at 1 through any number of cycles and any repeated writes of 1. They return to 0 only on a write to their control word with that bit at 0.
- R7: A read (`bus_rd`) of a control word returns, on the following cycle, the state of its 32 lines at the read edge, with 1 meaning asserted. `bus_rdata` holds its value while no read is issued.
- R8: A read of status word 0 (0x150) or status word 1 (0x154) returns the bitwise inverse of the corresponding control word's line states: 0 means asserted and 1 means released.
- R9: A write to any address other than 0x100 and 0x104, including the status addresses, leaves every output unchanged. A read from an address that is neither a control nor a status word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data, valid the cycle after the read |
| reset_out | output | 64 | Reset lines, 1 = asserted |

## Verification
The bench builds the block with PULSE_LEN set to 6 and keeps the default 64 lines, word width and addresses. The short pulse lets thousands of random cycles cover full pulse expiry, restarts that land in the middle of a pulse, and writes of 0 during a pulse many times over. Directed sequences also check the exact last cycle of a pulse and reach both held lines and both control words.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

  localparam int unsigned RC_NUM_OUT   = 64;
  localparam int unsigned RC_WORD_W    = 32;
  localparam int unsigned RC_ADDR_W    = 12;
  localparam int unsigned RC_PULSE_LEN = 16;
  localparam int unsigned RC_CTRL_BASE = 32'h100;
  localparam int unsigned RC_STAT_BASE = 32'h150;
  localparam int unsigned RC_HELD_A    = 12;
  localparam int unsigned RC_HELD_B    = 56;

  // Byte address of register word idx within a bank starting at base.
  function automatic int unsigned word_offset(input int unsigned base,
                                              input int unsigned idx,
                                              input int unsigned word_w);
    return base + idx * (word_w / 8);
  endfunction

endpackage

// File: rtl/rst_ctrl_decode.sv
module rst_ctrl_decode
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = RC_ADDR_W,
  parameter int unsigned WORD_W    = RC_WORD_W,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned CTRL_BASE = RC_CTRL_BASE,
  parameter int unsigned STAT_BASE = RC_STAT_BASE
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr,
  input  logic [NUM_WORDS*WORD_W-1:0] line_state,
  output logic [NUM_WORDS-1:0]        wr_word,
  output logic [WORD_W-1:0]           rd_word
);

  logic [NUM_WORDS-1:0] ctrl_hit;
  logic [NUM_WORDS-1:0] stat_hit;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(word_offset(CTRL_BASE, w, WORD_W));
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(word_offset(STAT_BASE, w, WORD_W));
    assign ctrl_hit[w] = (addr == CTRL_ADDR);
    assign stat_hit[w] = (addr == STAT_ADDR);
  end

  assign wr_word = ctrl_hit & {NUM_WORDS{wr}};

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (ctrl_hit[w]) rd_word = rd_word |  line_state[w*WORD_W +: WORD_W];
      if (stat_hit[w]) rd_word = rd_word | ~line_state[w*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/rst_ctrl_line.sv
module rst_ctrl_line
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned PULSE_LEN = RC_PULSE_LEN,
  parameter bit          HOLD      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic din,
  output logic active
);

  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  if (HOLD) begin : g_held
    logic hold_q;
    logic hold_d;
    logic hold_en;

    always_comb begin
      hold_en = load;
      hold_d  = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= 1'b0;
      else if (hold_en) hold_q <= hold_d;
    end

    assign active = hold_q;
  end else begin : g_pulse
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;
    logic             trig;

    always_comb begin
      trig   = load && din;
      cnt_en = trig || (cnt_q != '0);
      if (trig) cnt_d = CNT_W'(PULSE_LEN);
      else      cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
  end

endmodule

// File: rtl/rst_ctrl_unit.sv
module rst_ctrl_unit
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned NUM_OUT   = RC_NUM_OUT,
  parameter int unsigned WORD_W    = RC_WORD_W,
  parameter int unsigned ADDR_W    = RC_ADDR_W,
  parameter int unsigned PULSE_LEN = RC_PULSE_LEN,
  parameter int unsigned CTRL_BASE = RC_CTRL_BASE,
  parameter int unsigned STAT_BASE = RC_STAT_BASE,
  parameter int unsigned HELD_A    = RC_HELD_A,
  parameter int unsigned HELD_B    = RC_HELD_B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] reset_out
);

  localparam int unsigned NUM_WORDS = NUM_OUT / WORD_W;

  logic [NUM_WORDS-1:0] wr_word;
  logic [WORD_W-1:0]    rd_word;
  logic [WORD_W-1:0]    rdata_q;
  logic [WORD_W-1:0]    rdata_d;
  logic                 rdata_en;

  rst_ctrl_decode #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_decode (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .line_state (reset_out),
    .wr_word    (wr_word),
    .rd_word    (rd_word)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    localparam bit IS_HELD = (i == HELD_A) || (i == HELD_B);
    rst_ctrl_line #(
      .PULSE_LEN (PULSE_LEN),
      .HOLD      (IS_HELD)
    ) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wr_word[i / WORD_W]),
      .din    (bus_wdata[i % WORD_W]),
      .active (reset_out[i])
    );
  end

  always_comb begin
    rdata_en = bus_rd;
    rdata_d  = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/rst_ctrl_unit_chk.sv
module rst_ctrl_unit_chk
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned NUM_OUT   = RC_NUM_OUT,
  parameter int unsigned WORD_W    = RC_WORD_W,
  parameter int unsigned ADDR_W    = RC_ADDR_W,
  parameter int unsigned CTRL_BASE = RC_CTRL_BASE,
  parameter int unsigned STAT_BASE = RC_STAT_BASE,
  parameter int unsigned HELD_A    = RC_HELD_A
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [WORD_W-1:0]  bus_wdata,
  input logic               bus_rd,
  input logic [WORD_W-1:0]  bus_rdata,
  input logic [NUM_OUT-1:0] reset_out
);

  localparam int unsigned NUM_WORDS = NUM_OUT / WORD_W;
  localparam logic [ADDR_W-1:0] C0_ADDR = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] S0_ADDR = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] HA_ADDR =
    ADDR_W'(word_offset(CTRL_BASE, HELD_A / WORD_W, WORD_W));

  logic is_ctrl;
  logic is_mapped;

  always_comb begin
    is_ctrl   = 1'b0;
    is_mapped = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(word_offset(CTRL_BASE, w, WORD_W))) is_ctrl = 1'b1;
      if (bus_addr == ADDR_W'(word_offset(STAT_BASE, w, WORD_W))) is_mapped = 1'b1;
    end
    is_mapped = is_mapped || is_ctrl;
  end

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reset_out == '0 && bus_rdata == '0)); // R1

  AST_NO_WRITE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((reset_out & ~$past(reset_out)) == '0)); // R3

  AST_HELD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == HA_ADDR) |=> $stable(reset_out[HELD_A])); // R6

  AST_HELD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == HA_ADDR && bus_wdata[HELD_A % WORD_W]) |=> reset_out[HELD_A]); // R6

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == C0_ADDR) |=> (bus_rdata == $past(reset_out[WORD_W-1:0]))); // R7

  AST_STATUS_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == S0_ADDR) |=> (bus_rdata == ~$past(reset_out[WORD_W-1:0]))); // R8

  AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !is_ctrl) |=> ((reset_out & ~$past(reset_out)) == '0)); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped) |=> (bus_rdata == '0)); // R9

endmodule

bind rst_ctrl_unit rst_ctrl_unit_chk #(
  .NUM_OUT   (NUM_OUT),
  .WORD_W    (WORD_W),
  .ADDR_W    (ADDR_W),
  .CTRL_BASE (CTRL_BASE),
  .STAT_BASE (STAT_BASE),
  .HELD_A    (HELD_A)
) u_chk (.*);

// File: tb/rst_ctrl_unit_test.sv
`timescale 1ns/1ps
module rst_ctrl_unit_test;

  localparam int TB_PULSE = 6;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [63:0] reset_out;

  int checks = 0;
  int errors = 0;

  int cnt_m [64];
  bit held_m[64];
  bit         pend_rd;
  logic [31:0] exp_rd;
  string      rd_tag;

  rst_ctrl_unit #(.PULSE_LEN(TB_PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .reset_out(reset_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit is_held(input int i);
    return (i == 12) || (i == 56);
  endfunction

  function automatic logic [63:0] model_vec();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) v[i] = is_held(i) ? held_m[i] : (cnt_m[i] != 0);
    return v;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [63:0] v = model_vec();
    case (a)
      12'h100: return v[31:0];
      12'h104: return v[63:32];
      12'h150: return ~v[31:0];
      12'h154: return ~v[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [11:0] a);
    if (a == 12'h100 || a == 12'h104) return "R7";
    if (a == 12'h150 || a == 12'h154) return "R8";
    return "R9";
  endfunction

  task automatic model_step(input logic [11:0] a, input logic w, input logic [31:0] d);
    for (int i = 0; i < 64; i++) begin
      bit hit = w && (a == ((i < 32) ? 12'h100 : 12'h104));
      bit b   = d[i % 32];
      if (is_held(i)) begin
        if (hit) held_m[i] = b;
      end else if (hit && b) cnt_m[i] = TB_PULSE;
      else if (cnt_m[i] > 0) cnt_m[i] = cnt_m[i] - 1;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin
      cnt_m[i]  = 0;
      held_m[i] = 1'b0;
    end
    pend_rd = 1'b0;
  endtask

  task automatic check_now(input string tag);
    logic [63:0] ev = model_vec();
    checks++;
    if (reset_out !== ev) begin
      errors++;
      $display("FAIL %s reset_out actual=%h expected=%h", tag, reset_out, ev);
    end
    if (pend_rd) begin
      checks++;
      if (bus_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s bus_rdata actual=%h expected=%h", rd_tag, bus_rdata, exp_rd);
      end
    end
  endtask

  task automatic tick(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input logic r, input string tag);
    @(negedge clk);
    check_now(tag);
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
    @(posedge clk);
    if (r) begin
      exp_rd  = model_read(a);
      rd_tag  = read_tag(a);
      pend_rd = 1'b1;
    end else pend_rd = 1'b0;
    model_step(a, w, d);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(12'h000, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (reset_out !== 64'h0 || bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 after reset actual=%h/%h expected=0/0", reset_out, bus_rdata);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] addrs [6];
    void'($urandom(32'd20240611));
    addrs = '{12'h100, 12'h104, 12'h150, 12'h154, 12'h108, 12'h0fc};
    rst_n = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    model_clear();
    repeat (3) @(posedge clk);
    apply_reset(); // R1

    // R2: word and bit mapping, readback of both control words
    tick(12'h100, 1'b1, 32'h0000_0020, 1'b0, "R2");
    tick(12'h100, 1'b0, 32'h0, 1'b1, "R2");
    tick(12'h104, 1'b1, 32'h0000_0008, 1'b1, "R2");
    tick(12'h104, 1'b0, 32'h0, 1'b1, "R2");
    tick(12'h154, 1'b0, 32'h0, 1'b1, "R8");
    idle(TB_PULSE + 2, "R3");

    // R3: whole-core line 0 and line 7 pulse, exact length
    tick(12'h100, 1'b1, 32'h0000_0081, 1'b0, "R3");
    idle(TB_PULSE + 3, "R3");

    // R4: retrigger mid-pulse restarts count
    tick(12'h100, 1'b1, 32'h0000_0200, 1'b0, "R4");
    idle(3, "R4");
    tick(12'h100, 1'b1, 32'h0000_0200, 1'b0, "R4");
    idle(TB_PULSE + 2, "R4");

    // R5: writing 0 during a pulse has no effect
    tick(12'h104, 1'b1, 32'h8000_0000, 1'b0, "R5");
    tick(12'h104, 1'b1, 32'h0000_0000, 1'b0, "R5");
    tick(12'h104, 1'b1, 32'h0000_0000, 1'b1, "R5");
    idle(TB_PULSE + 1, "R5");

    // R6: held lines 12 and 56
    tick(12'h100, 1'b1, 32'h0000_1000, 1'b0, "R6");
    tick(12'h104, 1'b1, 32'h0100_0000, 1'b0, "R6");
    idle(3 * TB_PULSE, "R6");
    tick(12'h100, 1'b1, 32'h0000_1000, 1'b1, "R6");
    tick(12'h150, 1'b0, 32'h0, 1'b1, "R8");
    tick(12'h100, 1'b1, 32'h0000_0000, 1'b1, "R6");
    tick(12'h104, 1'b1, 32'hfeff_ffff, 1'b1, "R6");
    idle(TB_PULSE + 1, "R6");
    tick(12'h104, 1'b1, 32'h0000_0000, 1'b1, "R6");
    idle(2, "R6");

    // R9: stray writes and unmapped reads
    tick(12'h150, 1'b1, 32'hffff_ffff, 1'b0, "R9");
    tick(12'h154, 1'b1, 32'hffff_ffff, 1'b1, "R9");
    tick(12'h108, 1'b1, 32'hffff_ffff, 1'b1, "R9");
    tick(12'h0fc, 1'b1, 32'hffff_ffff, 1'b1, "R9");
    tick(12'h000, 1'b0, 32'h0, 1'b1, "R9");
    idle(2, "R9");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel = int'($urandom_range(0, 7));
      a = (sel < 6) ? addrs[sel] : 12'($urandom_range(0, 1023) << 2);
      d = $urandom() & $urandom();
      tick(a, ($urandom_range(0, 9) < 3), d, ($urandom_range(0, 1) == 1), "R3");
    end

    // R1: reset in the middle of activity
    tick(12'h100, 1'b1, 32'hffff_ffff, 1'b0, "R6");
    tick(12'h104, 1'b1, 32'hffff_ffff, 1'b1, "R6");
    apply_reset();
    tick(12'h100, 1'b0, 32'h0, 1'b1, "R1");
    idle(2, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule